// File: doc/BRIEF.md
# Partitioned Measurement Register Bank

This block holds the measurement registers of a security module that serves several execution contexts in turn. Registers 0 to 15 and a free-running tick counter form a global region that looks the same to every context. Registers 16 to 23 belong to whichever context is currently loaded. Hashing and signing are done elsewhere; new register values arrive already computed on the write port.

Access rights depend on which region an index falls in and on the mode inputs. The global region can be read by anyone but changes only when the requester is privileged and the control bit is clear. The per-context registers can be written in either mode, but only while a context is resident. A transfer engine streams the per-context group out to an external context buffer when a context is closed, and streams it back in when one is loaded. Reading indices 0 to 23 yields the values an attestation covers: the global set together with the resident context's set.

Top module: `mreg_bank`

## Requirements
- R1: A read of index 0..15 returns that global register's value on `rd_data_o` one cycle after `rd_idx_i` is sampled, whatever the mode inputs.
- R2: A write to index 0..15 or 24 changes the register only when `priv_i`=1 and `ctrl_bit_i`=0 and no transfer is running; otherwise the register keeps its value.
- R3: Index 24 is the tick counter. It increments by one every cycle, except in a cycle where an accepted write loads `wr_data_i` into it. A read of index 24 returns the count held at the sampling edge.
- R4: Every refused write to index 0..24 raises `wr_denied_o` for exactly the one cycle after the write is sampled.
- R5: Indices 16..23 read the resident context's registers. A write to them is accepted in either mode while `ctx_loaded_o`=1 and no transfer runs; otherwise it is refused.
- R6: `save_start_i` sampled while idle starts a save. Registers 16..23 are offered on `so_data_o` in ascending order, one per cycle with `so_valid_o`&&`so_ready_i`, and the beat for 23 has `so_last_o`=1. After the last beat, 16..23 read zero and `ctx_loaded_o`=0.
- R7: `load_start_i` sampled while idle (and `save_start_i` low) starts a restore. `ri_ready_o` is high and each `ri_valid_i` beat fills 16..23 in ascending order. After the eighth beat, `ctx_loaded_o`=1.
- R8: `busy_o` is high throughout a save or restore, and every write during it is refused. Start requests while busy are ignored, and save wins over restore when both are requested at once.
- R9: Indices 25..31 read as zero. Writes to them change nothing and do not raise `wr_denied_o`.
- R10: Reset (synchronous, active high) clears all registers and the tick counter, leaves the engine idle with no context loaded, and drives all outputs to zero.
- R11: Saving and restoring contexts leaves registers 0..15 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Requester runs in privileged mode |
| ctrl_bit_i | input | 1 | Control-register bit; global writes need 0 |
| rd_idx_i | input | 5 | Read index |
| rd_data_o | output | W | Registered read data |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 5 | Write index |
| wr_data_i | input | W | Precomputed new value |
| wr_denied_o | output | 1 | One-cycle pulse for a refused write |
| save_start_i | input | 1 | Begin streaming out the context group |
| load_start_i | input | 1 | Begin streaming in a context group |
| so_valid_o | output | 1 | Save beat valid |
| so_data_o | output | W | Save beat data |
| so_last_o | output | 1 | Save beat is register 23 |
| so_ready_i | input | 1 | Context buffer accepts save beat |
| ri_valid_i | input | 1 | Restore beat valid |
| ri_data_i | input | W | Restore beat data |
| ri_ready_o | output | 1 | Block accepts restore beat |
| busy_o | output | 1 | Transfer in progress |
| ctx_loaded_o | output | 1 | A context is resident |

## Verification
The bench builds the block with its defaults: 32-bit registers, 16 global and 8 per-context registers, and a 5-bit index. That leaves indices 25..31 in the index space, so out-of-range reads and writes are reachable. The random phase draws indices over the full 5-bit range and toggles both mode inputs, so every region meets every mode combination. It also raises start requests while transfers run and stalls both handshakes at random, which exercises mid-stream backpressure and the last-beat handover.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  typedef enum logic [1:0] {XF_IDLE = 2'd0, XF_SAVE = 2'd1, XF_LOAD = 2'd2} xfer_e;
endpackage

// File: rtl/mreg_shared.sv
module mreg_shared #(
  parameter int W  = 32,
  parameter int NS = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic          tick_we,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  tick
);
  logic [W-1:0] mem [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NS; i++)
        if (widx == IW'(i)) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tick <= '0;
    else if (tick_we) tick <= wdata;
    else              tick <= tick + W'(1);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NS; i++)
      if (ridx == IW'(i)) rdata = mem[i];
  end

  // R3
  tick_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_we |=> tick == $past(tick) + W'(1));
endmodule

// File: rtl/mreg_ctx.sv
module mreg_ctx
  import mreg_pkg::*;
#(
  parameter int W  = 32,
  parameter int NS = 16,
  parameter int NC = 8,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata,
  input  logic          save_start,
  input  logic          load_start,
  output logic          so_valid,
  output logic [W-1:0]  so_data,
  output logic          so_last,
  input  logic          so_ready,
  input  logic          ri_valid,
  input  logic [W-1:0]  ri_data,
  output logic          ri_ready,
  output logic          busy,
  output logic          loaded
);
  localparam int CW = $clog2(NC);
  localparam logic [CW-1:0] LAST = CW'(NC - 1);

  logic [W-1:0]  regs [NC];
  logic [CW-1:0] ptr;
  xfer_e         state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= XF_IDLE;
      ptr    <= '0;
      loaded <= 1'b0;
      for (int i = 0; i < NC; i++) regs[i] <= '0;
    end else begin
      case (state)
        XF_IDLE: begin
          if (we)
            for (int i = 0; i < NC; i++)
              if (widx == IW'(NS + i)) regs[i] <= wdata;
          ptr <= '0;
          if (save_start)      state <= XF_SAVE;
          else if (load_start) state <= XF_LOAD;
        end
        XF_SAVE: if (so_ready) begin
          if (ptr == LAST) begin
            state  <= XF_IDLE;
            loaded <= 1'b0;
            for (int i = 0; i < NC; i++) regs[i] <= '0;
          end else ptr <= ptr + CW'(1);
        end
        XF_LOAD: if (ri_valid) begin
          regs[ptr] <= ri_data;
          if (ptr == LAST) begin
            state  <= XF_IDLE;
            loaded <= 1'b1;
          end else ptr <= ptr + CW'(1);
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign busy     = (state != XF_IDLE);
  assign so_valid = (state == XF_SAVE);
  assign so_data  = regs[ptr];
  assign so_last  = so_valid && (ptr == LAST);
  assign ri_ready = (state == XF_LOAD);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NC; i++)
      if (ridx == IW'(NS + i)) rdata = regs[i];
  end

  // R6
  so_hold_chk: assert property (@(posedge clk) disable iff (rst)
    so_valid && !so_ready |=> so_valid && $stable(so_data));
  // R7
  load_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded) |-> $past(ri_valid && ri_ready));
endmodule

// File: rtl/mreg_bank.sv
module mreg_bank
  import mreg_pkg::*;
#(
  parameter int W  = 32,
  parameter int NS = 16,
  parameter int NC = 8,
  localparam int IW = $clog2(NS + NC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          priv_i,
  input  logic          ctrl_bit_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          wr_denied_o,
  input  logic          save_start_i,
  input  logic          load_start_i,
  output logic          so_valid_o,
  output logic [W-1:0]  so_data_o,
  output logic          so_last_o,
  input  logic          so_ready_i,
  input  logic          ri_valid_i,
  input  logic [W-1:0]  ri_data_i,
  output logic          ri_ready_o,
  output logic          busy_o,
  output logic          ctx_loaded_o
);
  localparam logic [IW-1:0] NS_I   = IW'(NS);
  localparam logic [IW-1:0] TICK_I = IW'(NS + NC);

  logic in_sh, in_ctx, in_tick, glob_ok;
  logic sh_we, tick_we, ctx_we, deny_c;
  logic [W-1:0] sh_rd, ctx_rd, tick;

  always_comb begin
    in_sh   = wr_idx_i < NS_I;
    in_tick = wr_idx_i == TICK_I;
    in_ctx  = !in_sh && (wr_idx_i < TICK_I);
    glob_ok = priv_i && !ctrl_bit_i && !busy_o;
    sh_we   = wr_en_i && in_sh && glob_ok;
    tick_we = wr_en_i && in_tick && glob_ok;
    ctx_we  = wr_en_i && in_ctx && ctx_loaded_o && !busy_o;
    deny_c  = wr_en_i && (in_sh || in_tick || in_ctx) && !(sh_we || tick_we || ctx_we);
  end

  mreg_shared #(.W(W), .NS(NS), .IW(IW)) u_shared (
    .clk(clk), .rst(rst), .we(sh_we), .widx(wr_idx_i), .wdata(wr_data_i),
    .tick_we(tick_we), .ridx(rd_idx_i), .rdata(sh_rd), .tick(tick)
  );

  mreg_ctx #(.W(W), .NS(NS), .NC(NC), .IW(IW)) u_ctx (
    .clk(clk), .rst(rst), .we(ctx_we), .widx(wr_idx_i), .wdata(wr_data_i),
    .ridx(rd_idx_i), .rdata(ctx_rd),
    .save_start(save_start_i), .load_start(load_start_i),
    .so_valid(so_valid_o), .so_data(so_data_o), .so_last(so_last_o), .so_ready(so_ready_i),
    .ri_valid(ri_valid_i), .ri_data(ri_data_i), .ri_ready(ri_ready_o),
    .busy(busy_o), .loaded(ctx_loaded_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o   <= '0;
      wr_denied_o <= 1'b0;
    end else begin
      wr_denied_o <= deny_c;
      if (rd_idx_i < NS_I)        rd_data_o <= sh_rd;
      else if (rd_idx_i == TICK_I) rd_data_o <= tick;
      else                         rd_data_o <= ctx_rd;
    end
  end

  // R4
  deny_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_denied_o |-> $past(wr_en_i));
  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !(sh_we || tick_we || ctx_we));
endmodule

// File: tb/sim_mreg_bank.sv
module sim_mreg_bank;
  logic clk = 1'b0, rst = 1'b1;
  logic priv = 0, cbit = 0, wr_en = 0, save_st = 0, load_st = 0, so_rdy = 0, ri_val = 0;
  logic [4:0] rd_idx = 0, wr_idx = 0;
  logic [31:0] wr_data = 0, ri_data = 0;
  logic [31:0] rd_data, so_data;
  logic den, so_val, so_last, ri_rdy, busy, loaded;

  always #5 clk = ~clk;

  mreg_bank u0 (
    .clk(clk), .rst(rst), .priv_i(priv), .ctrl_bit_i(cbit), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_denied_o(den),
    .save_start_i(save_st), .load_start_i(load_st), .so_valid_o(so_val), .so_data_o(so_data),
    .so_last_o(so_last), .so_ready_i(so_rdy), .ri_valid_i(ri_val), .ri_data_i(ri_data),
    .ri_ready_o(ri_rdy), .busy_o(busy), .ctx_loaded_o(loaded)
  );

  // behavioural reference model
  logic [31:0] m_sh [16];
  logic [31:0] m_cx [8];
  logic [31:0] m_tick = 0, e_rd = 0;
  int m_state = 0, m_ptr = 0;
  logic m_loaded = 0, e_den = 0, m_inrst = 0, swapped = 0;
  string rd_tag = "R10", den_tag = "R10";
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_sh[i] = 0;
      for (int i = 0; i < 8; i++) m_cx[i] = 0;
      m_tick = 0; e_rd = 0; e_den = 0; m_state = 0; m_ptr = 0; m_loaded = 0; m_inrst = 1;
    end else begin
      bit ok;
      bit inrange;
      m_inrst = 0;
      if (rd_idx < 16) begin e_rd = m_sh[rd_idx]; rd_tag = swapped ? "R11" : "R1"; end
      else if (rd_idx < 24) begin e_rd = m_cx[rd_idx-16]; rd_tag = "R5"; end
      else if (rd_idx == 24) begin e_rd = m_tick; rd_tag = "R3"; end
      else begin e_rd = 0; rd_tag = "R9"; end
      inrange = wr_idx <= 24;
      if (wr_idx < 16 || wr_idx == 24) ok = priv && !cbit && m_state == 0;
      else if (wr_idx < 24) ok = m_loaded && m_state == 0;
      else ok = 0;
      e_den = wr_en && inrange && !ok;
      if (!wr_en) den_tag = "R4";
      else if (m_state != 0) den_tag = "R8";
      else if (wr_idx < 16 || wr_idx == 24) den_tag = "R2";
      else if (wr_idx < 24) den_tag = "R5";
      else den_tag = "R9";
      if (wr_en && ok && wr_idx < 16) m_sh[wr_idx] = wr_data;
      if (wr_en && ok && wr_idx >= 16 && wr_idx < 24) m_cx[wr_idx-16] = wr_data;
      if (wr_en && ok && wr_idx == 24) m_tick = wr_data; else m_tick = m_tick + 1;
      case (m_state)
        0: begin
          m_ptr = 0;
          if (save_st) m_state = 1; else if (load_st) m_state = 2;
        end
        1: if (so_rdy) begin
          if (m_ptr == 7) begin
            m_state = 0; m_loaded = 0;
            for (int i = 0; i < 8; i++) m_cx[i] = 0;
          end else m_ptr++;
        end
        default: if (ri_val) begin
          m_cx[m_ptr] = ri_data;
          if (m_ptr == 7) begin m_state = 0; m_loaded = 1; swapped = 1; end else m_ptr++;
        end
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(m_inrst ? "R10" : rd_tag, rd_data, e_rd);
    chk(m_inrst ? "R10" : den_tag, {31'd0, den}, {31'd0, e_den});
    chk(m_inrst ? "R10" : "R6", {31'd0, so_val}, {31'd0, m_state == 1});
    if (m_state == 1) begin
      chk("R6", so_data, m_cx[m_ptr]);
      chk("R6", {31'd0, so_last}, {31'd0, m_ptr == 7});
    end
    chk(m_inrst ? "R10" : "R7", {31'd0, ri_rdy}, {31'd0, m_state == 2});
    chk(m_inrst ? "R10" : "R7", {31'd0, loaded}, {31'd0, m_loaded});
    chk(m_inrst ? "R10" : "R8", {31'd0, busy}, {31'd0, m_state != 0});
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic op(logic we, logic [4:0] wi, logic [31:0] wd, logic [4:0] ri);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri;
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R1 R2 R3: privileged global writes and readback
    priv = 1; cbit = 0;
    op(1, 3, 32'h1234, 3); op(0, 0, 0, 3); op(1, 24, 32'd100, 24); op(0, 0, 0, 24);
    // R2 R4: refused global writes
    cbit = 1; op(1, 3, 32'hdead, 3); op(0, 0, 0, 3);
    priv = 0; cbit = 0; op(1, 24, 32'd5, 24); op(0, 0, 0, 24);
    // R5: context write with nothing loaded; R9 out of range
    op(1, 18, 32'h55, 18); op(1, 27, 32'h66, 27); op(0, 0, 0, 27);
    // R7: restore with stalls
    load_st = 1; op(0, 0, 0, 0); load_st = 0;
    for (int k = 0; k < 18; k++) begin ri_val = (k % 2 == 0); ri_data = 32'd7 * k + 1; op(0, 0, 0, 5'(16 + k % 8)); end
    ri_val = 0;
    // R5 R11: context writes in unprivileged mode, reads across groups
    op(1, 20, 32'habc, 20); op(0, 0, 0, 20); op(0, 0, 0, 3);
    // R6 R8: save with backpressure and writes while busy
    priv = 1; save_st = 1; load_st = 1; op(0, 0, 0, 16); save_st = 0; load_st = 0;
    for (int k = 0; k < 20; k++) begin so_rdy = (k % 3 != 0); op(1, 5'(k % 25), 32'(k), 5'(16 + k % 8)); end
    so_rdy = 0; op(0, 0, 0, 17); op(0, 0, 0, 3);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      priv = $urandom_range(0, 1) == 1; cbit = $urandom_range(0, 3) == 0;
      save_st = $urandom_range(0, 15) == 0; load_st = $urandom_range(0, 15) == 0;
      so_rdy = $urandom_range(0, 1) == 1; ri_val = $urandom_range(0, 1) == 1; ri_data = $urandom;
      op($urandom_range(0, 1) == 1, 5'($urandom_range(0, 31)), $urandom, 5'($urandom_range(0, 31)));
    end
    cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule